// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Resolver

This block is the central arbiter of a slot-addressed interrupt system. Each interface slot has a select code, and a lower code means higher priority. Each slot reports two conditional bits. The request bit says the slot wants service. The holdoff bit is the complement of the priority-pass signal that the slot hands to the next slot down the chain. The resolver keeps both bits per slot. It walks the chain from code zero upward. It then grants the lowest-numbered request that no higher-priority slot is holding off.

A grant is announced combinationally on `irq_o`. On the next clock edge it is acknowledged: `ack_o` pulses for one cycle, `ack_code_o` carries the winner's select code, and the winner's request bit is cleared. The winner's holdoff bit is left untouched, so it keeps blocking every slot below it until software rewrites that slot. When the holdoff is later removed, a blocked request further down is granted automatically on the next edge, without any polling. A global interrupt enable gates all grants.

Top module: `irq_chain_resolver`

## Requirements
- R1: After a synchronous active-low reset, every request and holdoff bit is clear, `ack_o` and `irq_o` are 0, and `ack_code_o` is 0.
- R2: A clock edge with `wr_en_i` high stores `wr_req_i` and `wr_hold_i` as the request and holdoff bits of the slot whose select code is `wr_code_i`. No other slot is changed.
- R3: `irq_o` is high exactly when `ien_i` is high and some slot has its request set while every slot with a smaller code has its holdoff clear. A slot's own holdoff never blocks its own request.
- R4: When several requests are grantable, the winner is the one with the smallest select code. The edge after `irq_o` is seen puts the winner's 6-bit code on `ack_code_o`.
- R5: Every grant produces `ack_o` high for exactly that one following cycle, and the same edge clears the winner's request bit.
- R6: An acknowledge leaves the winner's holdoff bit unchanged. A winner whose holdoff is set keeps all higher-numbered requests from being granted.
- R7: While `ien_i` is low there is no grant and no acknowledge. Pending requests stay stored and are granted once `ien_i` returns high.
- R8: When a write clears a blocking holdoff, the highest-priority request below it that is now unblocked is acknowledged on the edge after the write takes effect.
- R9: `ack_code_o` keeps its value in every cycle in which `ack_o` is low.
- R10: If a write and an acknowledge target the same slot on the same edge, the written values win.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Write strobe for one slot's bits |
| wr_code_i | input | 6 | Select code of the slot being written |
| wr_req_i | input | 1 | Request bit to store |
| wr_hold_i | input | 1 | Holdoff bit to store |
| irq_o | output | 1 | A grantable request exists (combinational) |
| ack_o | output | 1 | One-cycle acknowledge pulse |
| ack_code_o | output | 6 | Select code of the most recent winner |

## Verification
The bench builds the resolver with its default parameters: 64 slots and a 6-bit code. This puts both ends of the chain within reach, namely code 0, which blocks every other slot, and code 63, which every other slot can block. A random phase confines most writes to codes 0 to 7. With so few codes, the same slot is often written and acknowledged on the same edge, and holdoff releases often cascade into fresh grants.

// File: rtl/irq_chain_pkg.sv
// Shared helpers for the interrupt chain resolver.
// Assumes slot counts of at least two.
package irq_chain_pkg;

    localparam int DEF_SLOTS = 64;

    // Width needed to address n slots, at least one bit.
    function automatic int code_bits(input int n);
        int w;
        w = 1;
        while ((1 << w) < n) w++;
        return w;
    endfunction

endpackage

// File: rtl/slot_state_regs.sv
// Per-slot request and holdoff storage.
// A write from software has precedence over an acknowledge clear of the same slot.
// Assumes clr_code is valid whenever clr_en is high.
module slot_state_regs #(
    parameter int N_SLOTS = 64,
    parameter int CW      = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CW-1:0]      wr_code,
    input  logic               wr_req,
    input  logic               wr_hold,
    input  logic               clr_en,
    input  logic [CW-1:0]      clr_code,
    output logic [N_SLOTS-1:0] req_vec,
    output logic [N_SLOTS-1:0] hold_vec
);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic hit_wr;
        logic hit_clr;
        assign hit_wr  = wr_en  && (wr_code  == CW'(g));
        assign hit_clr = clr_en && (clr_code == CW'(g));

        // Update one slot: a write first, otherwise an acknowledge clears the request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_vec[g]  <= 1'b0;
                hold_vec[g] <= 1'b0;
            end else if (hit_wr) begin
                req_vec[g]  <= wr_req;
                hold_vec[g] <= wr_hold;
            end else if (hit_clr) begin
                req_vec[g]  <= 1'b0;
            end
        end
    end

    // R5
    // ack_clears_req_chk
    ack_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(wr_en && wr_code == clr_code)) |=> !req_vec[$past(clr_code)]);

    // R6
    // hold_kept_chk
    hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wr_en) |=> $stable(hold_vec));

endmodule

// File: rtl/chain_priority_scan.sv
// Priority chain evaluation. The pass-in signal of each slot is the AND of the
// pass-out signals of all lower-numbered slots, where pass-out is the complement
// of the holdoff bit. Among the candidates the lowest code is picked and encoded.
// Purely combinational.
module chain_priority_scan #(
    parameter int N_SLOTS = 64,
    parameter int CW      = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ien,
    input  logic [N_SLOTS-1:0] req_vec,
    input  logic [N_SLOTS-1:0] hold_vec,
    output logic               found,
    output logic [CW-1:0]      win_code
);

    logic [N_SLOTS-1:0] pass_in;
    logic [N_SLOTS-1:0] cand;
    logic [N_SLOTS-1:0] earlier;
    logic [N_SLOTS-1:0] grant_vec;

    assign pass_in[0] = 1'b1;
    assign earlier[0] = 1'b0;
    for (genvar g = 1; g < N_SLOTS; g++) begin : g_chain
        assign pass_in[g] = pass_in[g-1] & ~hold_vec[g-1];
        assign earlier[g] = earlier[g-1] | cand[g-1];
    end

    assign cand      = req_vec & pass_in;
    assign grant_vec = cand & ~earlier & {N_SLOTS{ien}};
    assign found     = |grant_vec;

    // Encode the single granted slot into its select code.
    always_comb begin
        win_code = '0;
        for (int i = 0; i < N_SLOTS; i++)
            if (grant_vec[i]) win_code = win_code | CW'(i);
    end

    // R3
    // winner_requests_chk
    winner_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (req_vec[win_code] && ien));

    // R4
    // single_grant_chk
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

endmodule

// File: rtl/ack_issuer.sv
// Registers the acknowledge pulse and the winner code.
// The code register changes only when a new grant is taken.
module ack_issuer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          found,
    input  logic [CW-1:0] win_code,
    output logic          ack,
    output logic [CW-1:0] ack_code
);

    // Pulse the acknowledge and capture the winner's code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack      <= 1'b0;
            ack_code <= '0;
        end else begin
            ack <= found;
            if (found) ack_code <= win_code;
        end
    end

    // R9
    // code_held_chk
    code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> $stable(ack_code));

endmodule

// File: rtl/irq_chain_resolver.sv
// Top of the interrupt chain resolver: slot storage, chain scan, acknowledge.
// A grant taken on one edge clears the winner's request on that same edge, so
// each resolution yields exactly one acknowledge pulse.
module irq_chain_resolver #(
    parameter int N_SLOTS = irq_chain_pkg::DEF_SLOTS,
    parameter int CW      = irq_chain_pkg::code_bits(N_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ien_i,
    input  logic          wr_en_i,
    input  logic [CW-1:0] wr_code_i,
    input  logic          wr_req_i,
    input  logic          wr_hold_i,
    output logic          irq_o,
    output logic          ack_o,
    output logic [CW-1:0] ack_code_o
);

    logic [N_SLOTS-1:0] req_vec;
    logic [N_SLOTS-1:0] hold_vec;
    logic               found;
    logic [CW-1:0]      win_code;

    slot_state_regs #(.N_SLOTS(N_SLOTS), .CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .wr_code  (wr_code_i),
        .wr_req   (wr_req_i),
        .wr_hold  (wr_hold_i),
        .clr_en   (found),
        .clr_code (win_code),
        .req_vec  (req_vec),
        .hold_vec (hold_vec)
    );

    chain_priority_scan #(.N_SLOTS(N_SLOTS), .CW(CW)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .ien      (ien_i),
        .req_vec  (req_vec),
        .hold_vec (hold_vec),
        .found    (found),
        .win_code (win_code)
    );

    ack_issuer #(.CW(CW)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .found    (found),
        .win_code (win_code),
        .ack      (ack_o),
        .ack_code (ack_code_o)
    );

    assign irq_o = found;

    // R7
    // no_ack_without_ien_chk
    no_ack_without_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(ien_i));

endmodule

// File: tb/tb_irq_chain_resolver.sv
module tb_irq_chain_resolver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ien_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [5:0] wr_code_i = '0;
    logic       wr_req_i = 1'b0;
    logic       wr_hold_i = 1'b0;
    logic       irq_o;
    logic       ack_o;
    logic [5:0] ack_code_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    bit m_req  [64];
    bit m_hold [64];
    bit m_ack  = 1'b0;
    int m_code = 0;

    always #5 clk = ~clk;

    irq_chain_resolver dut (
        .clk(clk), .rst_n(rst_n), .ien_i(ien_i), .wr_en_i(wr_en_i),
        .wr_code_i(wr_code_i), .wr_req_i(wr_req_i), .wr_hold_i(wr_hold_i),
        .irq_o(irq_o), .ack_o(ack_o), .ack_code_o(ack_code_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Lowest grantable slot, or -1
    function automatic int model_winner();
        bit blocked = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (m_req[i] && !blocked) return i;
            if (m_hold[i]) blocked = 1'b1;
        end
        return -1;
    endfunction

    // Model update on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) begin m_req[i] = 0; m_hold[i] = 0; end
            m_ack = 0; m_code = 0;
        end else begin
            int w;
            w = model_winner();
            m_ack = ien_i && (w >= 0);
            if (m_ack) begin m_code = w; m_req[w] = 0; end
            if (wr_en_i) begin
                m_req[wr_code_i]  = wr_req_i;   // R10: write after clear
                m_hold[wr_code_i] = wr_hold_i;
            end
        end
    end

    // Compare against model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(irq_o == (ien_i && model_winner() >= 0), "R3 irq", irq_o, ien_i && model_winner() >= 0);
            chk(ack_o == m_ack, "R5 ack", ack_o, m_ack);
            chk(ack_code_o == m_code[5:0], "R4/R9 code", ack_code_o, m_code);
        end
    end

    task automatic do_write(input int code, input bit r, input bit h);
        @(negedge clk); #1;
        wr_en_i = 1; wr_code_i = code[5:0]; wr_req_i = r; wr_hold_i = h;
        @(negedge clk); #1;
        wr_en_i = 0;
    endtask

    task automatic wait_ack(output bit got, output int code);
        got = 0; code = -1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (ack_o) begin got = 1; code = ack_code_o; break; end
        end
    endtask

    initial begin
        bit got;
        int code;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ack_o == 0 && irq_o == 0, "R1 outputs", ack_o, 0);
        chk(ack_code_o == 0, "R1 code", ack_code_o, 0);
        #1 rst_n = 1;
        @(negedge clk);
        chk(irq_o == 0, "R1 no request", irq_o, 0);

        // R7: requests stored while disabled
        do_write(9, 1, 1);
        do_write(3, 1, 1);
        do_write(40, 1, 0);
        @(negedge clk);
        chk(irq_o == 0 && ack_o == 0, "R7 disabled", irq_o, 0);
        #1 ien_i = 1;
        // R2 R4: lowest pending slot wins
        wait_ack(got, code);
        chk(got && code == 3, "R4 first winner", code, 3);
        @(negedge clk);
        // R6: holdoff of 3 blocks 9 and 40
        chk(ack_o == 0 && irq_o == 0, "R6 blocked", irq_o, 0);
        repeat (3) @(negedge clk);
        chk(ack_code_o == 3, "R9 held code", ack_code_o, 3);

        // R8: release cascades
        do_write(3, 0, 0);
        wait_ack(got, code);
        chk(got && code == 9, "R8 release to 9", code, 9);
        do_write(9, 0, 0);
        wait_ack(got, code);
        chk(got && code == 40, "R8 release to 40", code, 40);

        // Boundaries: slot 63 and slot 0
        do_write(63, 1, 0);
        wait_ack(got, code);
        chk(got && code == 63, "R4 slot 63", code, 63);
        do_write(0, 1, 1);
        wait_ack(got, code);
        chk(got && code == 0, "R4 slot 0", code, 0);
        do_write(5, 1, 0);
        @(negedge clk);
        chk(irq_o == 0, "R6 slot 0 blocks all", irq_o, 0);
        do_write(0, 0, 0);
        wait_ack(got, code);
        chk(got && code == 5, "R8 release to 5", code, 5);

        // Random phase, mostly low codes
        for (int n = 0; n < 600; n++) begin
            @(negedge clk); #1;
            ien_i     = ($urandom_range(0, 7) != 0);
            wr_en_i   = $urandom_range(0, 1);
            wr_code_i = ($urandom_range(0, 9) == 0) ? 6'd63 : 6'($urandom_range(0, 7));
            wr_req_i  = $urandom_range(0, 1);
            wr_hold_i = ($urandom_range(0, 2) == 0);
        end
        @(negedge clk); #1 wr_en_i = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #500000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule